// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

The block runs on the slow real-time clock and controls a power-down state. Software writes a command bit to put the system into hibernate. The block then drops the power-enable output and holds the system reset low. During hibernate it watches an active-low wakeup pin.

A wakeup is accepted only when the pin has stayed low for a programmed number of ticks. Power is then restored, and reset is kept low for a second programmed number of ticks before it is released. The block then returns to its running state.

Both durations live in write-only-granular fields. Only a band of upper bits is stored, and a value larger than the field can hold is clamped to the field maximum.

Top module: `hib_wake_ctrl`

## Requirements
- R1: After reset `powerEn` and `resetN` are 1, and reads of offsets 0x20, 0x24 and 0x28 return 0.
- R2: In the running state, a write to offset 0x20 with bit 0 set makes `powerEn` and `resetN` low after the next clock edge, and offset 0x20 then reads 1 in bit 0. A write there with bit 0 clear has no effect.
- R3: The wakeup filter field at offset 0x24 stores only bits 15:5. Other bits read 0, and any written value above 0xFFE0 reads back as 0xFFE0.
- R4: The reset length field at offset 0x28 stores only bits 11:5. Other bits read 0, and any written value above 0x0FE0 reads back as 0x0FE0.
- R5: In hibernate, a wakeup with filter value F is accepted at the (F+1)-th consecutive rising edge at which `wakeN` is sampled low. `powerEn` rises after that edge. While `wakeN` stays high the block stays in hibernate.
- R6: A single sampled high level on `wakeN` during hibernate restarts the filter count from zero.
- R7: With reset length R > 0, `resetN` stays low for exactly R cycles after `powerEn` rises and then goes high. With R = 0, `resetN` and `powerEn` rise on the same edge.
- R8: After release, offset 0x20 reads 0. In the running state, `wakeN` has no effect on the outputs.
- R9: A hibernate command written while hibernating or waking has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow real-time clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write offset |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read offset |
| rdData | output | DATA_W | Combinational read data |
| wakeN | input | 1 | Active-low wakeup pin, already synchronized |
| powerEn | output | 1 | Power enable, low while hibernating |
| resetN | output | 1 | Active-low system reset |

## Verification
Four stimulus patterns are used on `wakeN`:
- A held-low pulse of exactly F+1 edges checks that acceptance is neither early nor late.
- A pulse of F low edges, one high edge and another full run shows that the count restarts rather than accumulates.
- A long low level in the running state and a long high level in hibernate show that the pin is ignored outside the filter window.
- A zero filter and zero reset length separate the single-edge and same-edge corner from the counted case.

Register writes with stray low bits and with oversize values tell masking apart from clamping.

// File: rtl/hib_wake_pkg.sv
package hib_wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_RESET = 2'd2
  } hibState_t;

  // Strobes from the sequencer to the counters
  typedef struct packed {
    logic filtClr;
    logic filtInc;
    logic rstLoad;
    logic rstInc;
  } hibStrobe_t;

endpackage

// File: rtl/hib_sat_field.sv
module hib_sat_field #(
  parameter int DATA_W = 32,
  parameter int HI     = 15,
  parameter int LO     = 5,
  localparam int OUT_W = HI + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  output logic [OUT_W-1:0]  value
);

  localparam logic [DATA_W-1:0] MASK =
    DATA_W'(((64'd1 << (HI + 1)) - 64'd1) & ~((64'd1 << LO) - 64'd1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      value <= '0;
    else if (wrStb)
      value <= (wrData > MASK) ? MASK[OUT_W-1:0] : (wrData[OUT_W-1:0] & MASK[OUT_W-1:0]);
  end

  // R3 / R4: unimplemented low bits never hold a one
  a_r3_field_clear_bits: assert property (@(posedge clk) disable iff (!rstN)
    (value & ~MASK[OUT_W-1:0]) == '0);

endmodule

// File: rtl/hib_wake_data.sv
module hib_wake_data
  import hib_wake_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int FILT_HI = 15,
  parameter int FILT_LO = 5,
  parameter int RST_HI = 11,
  parameter int RST_LO = 5,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h20,
  parameter logic [ADDR_W-1:0] FILT_OFS = 8'h24,
  parameter logic [ADDR_W-1:0] RST_OFS  = 8'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              asleep,
  input  hibStrobe_t        strobe,
  output logic              hibCmd,
  output logic              filtHit,
  output logic              rstDone,
  output logic              rstZero
);

  localparam int FILT_W = FILT_HI + 1;
  localparam int RST_W  = RST_HI + 1;

  logic [FILT_W-1:0] filtVal, filtCnt;
  logic [RST_W-1:0]  rstVal, rstCnt;

  assign hibCmd = wrEn && (wrAddr == CMD_OFS) && wrData[0];

  hib_sat_field #(.DATA_W(DATA_W), .HI(FILT_HI), .LO(FILT_LO)) u_filtField (
    .clk(clk), .rstN(rstN), .wrStb(wrEn && (wrAddr == FILT_OFS)),
    .wrData(wrData), .value(filtVal));

  hib_sat_field #(.DATA_W(DATA_W), .HI(RST_HI), .LO(RST_LO)) u_rstField (
    .clk(clk), .rstN(rstN), .wrStb(wrEn && (wrAddr == RST_OFS)),
    .wrData(wrData), .value(rstVal));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      filtCnt <= '0;
    else if (strobe.filtClr)
      filtCnt <= '0;
    else if (strobe.filtInc)
      filtCnt <= filtCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rstCnt <= '0;
    else if (strobe.rstLoad)
      rstCnt <= RST_W'(1);
    else if (strobe.rstInc)
      rstCnt <= rstCnt + 1'b1;
  end

  // Compare with >= so a field rewritten mid-count cannot strand the sequence
  assign filtHit = filtCnt >= filtVal;
  assign rstDone = rstCnt >= rstVal;
  assign rstZero = rstVal == '0;

  always_comb begin
    rdData = '0;
    if (rdAddr == CMD_OFS)       rdData = {{(DATA_W-1){1'b0}}, asleep};
    else if (rdAddr == FILT_OFS) rdData = {{(DATA_W-FILT_W){1'b0}}, filtVal};
    else if (rdAddr == RST_OFS)  rdData = {{(DATA_W-RST_W){1'b0}}, rstVal};
  end

  // R6: a clear request leaves the filter count at zero
  a_r6_filter_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobe.filtClr |=> (filtCnt == '0));

  // R7: a loaded reset count is never zero while counting
  a_r7_count_loaded: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rstLoad |=> (rstCnt != '0));

endmodule

// File: rtl/hib_wake_fsm.sv
module hib_wake_fsm
  import hib_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hibCmd,
  input  logic       wakeN,
  input  logic       filtHit,
  input  logic       rstDone,
  input  logic       rstZero,
  output hibStrobe_t strobe,
  output logic       asleep,
  output logic       powerEn,
  output logic       resetN
);

  hibState_t state, stateNxt;
  logic      pinLow, accept;

  assign pinLow = (state == ST_SLEEP) && !wakeN;
  assign accept = pinLow && filtHit;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN:   if (hibCmd) stateNxt = ST_SLEEP;
      ST_SLEEP: if (accept) stateNxt = rstZero ? ST_RUN : ST_RESET;
      ST_RESET: if (rstDone) stateNxt = ST_RUN;
      default:  stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    strobe.filtClr = !pinLow;
    strobe.filtInc = pinLow && !filtHit;
    strobe.rstLoad = accept;
    strobe.rstInc  = (state == ST_RESET) && !rstDone;
  end

  assign asleep  = state != ST_RUN;
  assign powerEn = state != ST_SLEEP;
  assign resetN  = state == ST_RUN;

  a_r2_enter_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && hibCmd) |=> (!powerEn && !resetN));

  a_r5_pin_high_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && wakeN) |=> (state == ST_SLEEP));

  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESET && rstDone) |=> (powerEn && resetN));

  a_r9_cmd_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESET && !rstDone && hibCmd) |=> (state == ST_RESET));

endmodule

// File: rtl/hib_wake_ctrl.sv
module hib_wake_ctrl
  import hib_wake_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int FILT_HI = 15,
  parameter int FILT_LO = 5,
  parameter int RST_HI = 11,
  parameter int RST_LO = 5,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h20,
  parameter logic [ADDR_W-1:0] FILT_OFS = 8'h24,
  parameter logic [ADDR_W-1:0] RST_OFS  = 8'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wakeN,
  output logic              powerEn,
  output logic              resetN
);

  hibStrobe_t strobe;
  logic hibCmd, filtHit, rstDone, rstZero, asleep;

  hib_wake_data #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .FILT_HI(FILT_HI), .FILT_LO(FILT_LO), .RST_HI(RST_HI), .RST_LO(RST_LO),
    .CMD_OFS(CMD_OFS), .FILT_OFS(FILT_OFS), .RST_OFS(RST_OFS)
  ) u_data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .asleep(asleep), .strobe(strobe),
    .hibCmd(hibCmd), .filtHit(filtHit), .rstDone(rstDone), .rstZero(rstZero));

  hib_wake_fsm u_fsm (
    .clk(clk), .rstN(rstN), .hibCmd(hibCmd), .wakeN(wakeN),
    .filtHit(filtHit), .rstDone(rstDone), .rstZero(rstZero),
    .strobe(strobe), .asleep(asleep), .powerEn(powerEn), .resetN(resetN));

endmodule

// File: tb/hib_wake_ctrl_tb.sv
module hib_wake_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  pe;
    logic  rn;
    int    cyc;
    string req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        wakeN = 1'b1;
  logic        powerEn, resetN;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit monOn = 1'b0;
  logic [1:0] prevOut;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hib_wake_ctrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .wakeN(wakeN),
    .powerEn(powerEn), .resetN(resetN));

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: every output change must match the next queued expectation
  always @(negedge clk) begin
    if (monOn && {powerEn, resetN} !== prevOut) begin
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R8: actual unexpected change to pe/rn=%b expected no change",
                 {powerEn, resetN});
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check({e.req, " outputs"}, {30'd0, powerEn, resetN}, {30'd0, e.pe, e.rn});
        check({e.req, " cycle"}, cyc, e.cyc);
      end
      prevOut = {powerEn, resetN};
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    rdAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic enterSleep();
    expItem_t e;
    @(negedge clk);
    e.pe = 1'b0; e.rn = 1'b0; e.cyc = cyc + 1; e.req = "R2";
    expQ.push_back(e);
    wrEn = 1'b1; wrAddr = 8'h20; wrData = 32'h1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Drive a full accepted wakeup with filter f and reset length r
  task automatic wakeUp(input int f, input int r);
    expItem_t e;
    int c;
    @(negedge clk);
    c = cyc;
    e.pe = 1'b1; e.rn = (r == 0); e.cyc = c + f + 1; e.req = "R5";
    expQ.push_back(e);
    if (r > 0) begin
      e.pe = 1'b1; e.rn = 1'b1; e.cyc = c + f + 1 + r; e.req = "R7";
      expQ.push_back(e);
    end
    wakeN = 1'b0;
    repeat (f + 1) @(negedge clk);
    wakeN = 1'b1;
    repeat (r + 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 powerEn", {31'd0, powerEn}, 32'd1);
    check("R1 resetN", {31'd0, resetN}, 32'd1);
    regRead("R1 cmd", 8'h20, 32'h0);
    regRead("R1 filter", 8'h24, 32'h0);
    regRead("R1 reset", 8'h28, 32'h0);
    prevOut = {powerEn, resetN};
    monOn = 1'b1;

    // R3 / R4 masking and clamping
    regWrite(8'h24, 32'h0000_ABCD); regRead("R3 mask", 8'h24, 32'h0000_ABC0);
    regWrite(8'h24, 32'h0001_0000); regRead("R3 clamp", 8'h24, 32'h0000_FFE0);
    regWrite(8'h24, 32'hFFFF_FFFF); regRead("R3 clamp all", 8'h24, 32'h0000_FFE0);
    regWrite(8'h28, 32'h0000_0BFF); regRead("R4 mask", 8'h28, 32'h0000_0BE0);
    regWrite(8'h28, 32'h0000_2000); regRead("R4 clamp", 8'h28, 32'h0000_0FE0);

    // R2: command with bit 0 clear does nothing (monitor flags any change)
    regWrite(8'h20, 32'hFFFF_FFFE);
    regRead("R2 no-op", 8'h20, 32'h0);

    // Filter 32, reset length 64
    regWrite(8'h24, 32'h0000_003F); regRead("R3 set", 8'h24, 32'h20);
    regWrite(8'h28, 32'h0000_005F); regRead("R4 set", 8'h28, 32'h40);

    // R8: pin ignored while running
    @(negedge clk); wakeN = 1'b0;
    repeat (40) @(negedge clk);
    wakeN = 1'b1;
    check("R8 run pin ignored", {30'd0, powerEn, resetN}, 32'd3);

    enterSleep();
    regRead("R2 status", 8'h20, 32'h1);
    // R9: repeated command while asleep
    regWrite(8'h20, 32'h1);
    // R5: long high level keeps sleeping
    repeat (50) @(negedge clk);
    check("R5 stays asleep", {30'd0, powerEn, resetN}, 32'd0);
    // R6: 32 low edges, one high, restarts the count
    wakeN = 1'b0;
    repeat (32) @(negedge clk);
    wakeN = 1'b1;
    @(negedge clk);
    check("R6 no early wake", {30'd0, powerEn, resetN}, 32'd0);
    wakeUp(32, 64);
    regRead("R8 status cleared", 8'h20, 32'h0);

    // Zero filter and zero reset length
    regWrite(8'h24, 32'h0000_001F); regRead("R3 zero", 8'h24, 32'h0);
    regWrite(8'h28, 32'h0000_001F); regRead("R4 zero", 8'h28, 32'h0);
    enterSleep();
    wakeUp(0, 0);
    regRead("R8 status cleared again", 8'h20, 32'h0);

    repeat (5) @(negedge clk);
    check("R7 queue drained", expQ.size(), 32'd0);
    finishRun();
  end

endmodule